// File: doc/BRIEF.md
# Single-Bit Fourth-Order Delta-Sigma Modulator

This block turns a signed fractional control word into a one-bit stream for the dual-modulus divider of a fractional-N synthesizer. The average of the stream sets the fractional part of the division ratio. Each output bit picks the modulus for one reference period. Quantization noise is pushed to high frequencies, where the loop filter of the synthesizer removes it.

The loop is a chain of four integrators with distributed feedback. The one-bit decision is fed back into every integrator as a fixed weight of plus or minus 31488, so the total span is 62976. The feedback weights are power-of-two sums. With them the noise transfer function has four zeros at DC and four poles near z = 0.75, which keeps the out-of-band noise gain flat and modest. An output of 1 stands for +31488 and an output of 0 stands for -31488. The density of ones is therefore 0.5 + k/62976, and the integer divider program absorbs the 0.5 offset. Each LSB of k moves the output frequency by the modulator clock divided by 62976.

The input is clamped to a stable range of plus or minus 12288, which is a parameter. The integrators saturate instead of wrapping. A flag reports any cycle in which an integrator hit its rail.

Top module: `sdm4_modulator`

## Requirements
- R1: A synchronous reset clears all four integrators. In the cycle after any clock edge that samples reset high, `bitOut` is 1 and `overload` is 0.
- R2: After reset is released, the first output bit is 1 (the quantizer decides 1 on a zero or positive value) and the second output bit is 0. This holds for any input.
- R3: For a constant input |k| <= 12288, the fraction of ones over 16384 consecutive output bits is within 0.001 of 0.5 + k/62976. Here bit 1 stands for +31488 and bit 0 stands for -31488.
- R4: An input above +12288 produces exactly the bit stream of +12288, and an input below -12288 produces exactly the bit stream of -12288.
- R5: The input passes through four integrators before it reaches the quantizer. The first four output bits after reset are therefore the same for every input value.
- R6: `overload` rises one cycle after an integrator saturates. It stays 0 throughout operation with inputs inside the clamp range.
- R7: A new input value takes effect without a reset. Over the 16384 bits that follow the change, the fraction of ones meets the R3 tolerance for the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| fracWord | input | 17 | Signed fractional control word k |
| bitOut | output | 1 | Modulus-select bit, 1 stands for +31488 |
| overload | output | 1 | High in the cycle after an integrator saturated |

## Verification
`bitOut` comes from the last integrator register. A new bit is therefore valid one cycle after each edge, and the bench reads it at the following falling clock edge. It collects exactly one bit per cycle from the falling edge at which reset drops. A change of `fracWord` goes through four integrator registers before it can reach the quantizer. For that reason the latency and clamp checks compare whole recorded streams bit by bit, starting at the first bit after reset. `overload` is a register fed by the saturation detectors, and it is sampled at every falling edge of each run.

// File: rtl/sdm4_pkg.sv
package sdm4_pkg;

  localparam int STAGES = 4;

  // control to datapath strobes
  typedef struct packed {
    logic clear;   // synchronous clear of all integrators
    logic fbPos;   // feedback polarity: 1 subtracts the positive level
  } sdmStrobe_t;

  // feedback weight of each integrator, in units of the half span.
  // Chosen so that D(w) = (w + 1/4)^4 with w = z - 1, after scaling
  // all states by 256: 1, 4*64/16, 6*256/16, 4*256/4 -> 1, 16, 96, 256.
  function automatic int fbScale(input int stage);
    case (stage)
      0:       return 1;
      1:       return (1 << 4);
      2:       return (1 << 6) + (1 << 5);
      default: return (1 << 8);
    endcase
  endfunction

endpackage

// File: rtl/sdm4_datapath.sv
module sdm4_datapath
  import sdm4_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int K_W     = 17,
  parameter int K_LIMIT = 12288,
  parameter int FB_HALF = 31488
) (
  input  logic                  clk,
  input  sdmStrobe_t            strb,
  input  logic signed [K_W-1:0] kIn,
  output logic                  s4Neg,
  output logic                  clipAny
);

  localparam int EXT_W = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] ACC_MAX = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] ACC_MIN = {3'b111, {(ACC_W-1){1'b0}}};
  localparam logic signed [K_W-1:0]   K_HI    = K_W'(K_LIMIT);
  localparam logic signed [K_W-1:0]   K_LO    = -K_HI;

  logic signed [K_W-1:0]   kEff;
  logic signed [ACC_W-1:0] acc     [STAGES];
  logic signed [ACC_W-1:0] accNext [STAGES];
  logic [STAGES-1:0]       clipVec;

  // input clamp to the stable range
  always_comb begin
    if (kIn > K_HI)      kEff = K_HI;
    else if (kIn < K_LO) kEff = K_LO;
    else                 kEff = kIn;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam logic signed [EXT_W-1:0] FBW = EXT_W'(fbScale(g) * FB_HALF);
    logic signed [EXT_W-1:0] feed;
    logic signed [EXT_W-1:0] fbTerm;
    logic signed [EXT_W-1:0] sum;

    if (g == 0) begin : g_head
      assign feed = EXT_W'(kEff);
    end else begin : g_chain
      assign feed = EXT_W'(acc[g-1]);
    end

    assign fbTerm      = strb.fbPos ? FBW : -FBW;
    assign sum         = EXT_W'(acc[g]) + feed - fbTerm;
    assign clipVec[g]  = (sum > ACC_MAX) || (sum < ACC_MIN);
    assign accNext[g]  = (sum > ACC_MAX) ? ACC_MAX[ACC_W-1:0] :
                         (sum < ACC_MIN) ? ACC_MIN[ACC_W-1:0] :
                         sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < STAGES; i++) begin
      if (strb.clear) acc[i] <= '0;
      else            acc[i] <= accNext[i];
    end
  end

  assign s4Neg   = acc[STAGES-1][ACC_W-1];
  assign clipAny = |clipVec;

  // R4
  in_clamp_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (kEff <= K_HI) && (kEff >= K_LO));

  // R3
  fb_down_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.fbPos && !clipVec[0]) |=> (acc[0] < $past(acc[0])));

  // R3
  fb_up_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (!strb.fbPos && !clipVec[0]) |=> (acc[0] > $past(acc[0])));

endmodule

// File: rtl/sdm4_ctrl.sv
module sdm4_ctrl
  import sdm4_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       s4Neg,
  input  logic       clipAny,
  output sdmStrobe_t strb,
  output logic       bitOut,
  output logic       overload
);

  // quantizer: zero or positive decides 1
  always_comb begin
    strb.clear = rst;
    strb.fbPos = ~s4Neg;
    bitOut     = ~s4Neg;
  end

  always_ff @(posedge clk) begin
    if (rst) overload <= 1'b0;
    else     overload <= clipAny;
  end

  // R1
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bitOut && !overload));

  // R2
  second_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst, 2) && !$past(rst)) |-> !bitOut);

endmodule

// File: rtl/sdm4_modulator.sv
module sdm4_modulator
  import sdm4_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int K_W     = 17,
  parameter int K_LIMIT = 12288,
  parameter int FB_HALF = 31488
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [K_W-1:0] fracWord,
  output logic                  bitOut,
  output logic                  overload
);

  sdmStrobe_t strb;
  logic       s4Neg;
  logic       clipAny;

  sdm4_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .s4Neg    (s4Neg),
    .clipAny  (clipAny),
    .strb     (strb),
    .bitOut   (bitOut),
    .overload (overload)
  );

  sdm4_datapath #(
    .ACC_W   (ACC_W),
    .K_W     (K_W),
    .K_LIMIT (K_LIMIT),
    .FB_HALF (FB_HALF)
  ) i_datapath (
    .clk     (clk),
    .strb    (strb),
    .kIn     (fracWord),
    .s4Neg   (s4Neg),
    .clipAny (clipAny)
  );

endmodule

// File: tb/test_sdm4_modulator.sv
module test_sdm4_modulator;

  localparam int NWIN   = 16384;
  localparam int NCAP   = 256;
  localparam int NVEC   = 6;
  // stimulus k and expected density of ones in parts per million
  localparam int VEC_K   [NVEC] = '{0, 1, -1, 5000, -9999, 12288};
  localparam int VEC_PPM [NVEC] = '{500000, 500016, 499984, 579395, 341225, 695122};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [16:0] fracWord = '0;
  logic               bitOut;
  logic               overload;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic capA [NCAP];
  logic capB [NCAP];

  always #10 clk = ~clk;

  sdm4_modulator i_sdm4_modulator (
    .clk      (clk),
    .rst      (rst),
    .fracWord (fracWord),
    .bitOut   (bitOut),
    .overload (overload)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int k);
    @(negedge clk);
    rst      = 1'b1;
    fracWord = 17'(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // counts ones over n bits starting at the current falling edge
  task automatic runWindow(input int n, output longint ones, output bit sawOvl);
    ones   = 0;
    sawOvl = 0;
    for (int i = 0; i < n; i++) begin
      ones   += longint'(bitOut);
      sawOvl |= overload;
      @(negedge clk);
    end
  endtask

  task automatic capture(input int k, input bit toA, output bit sawOvl);
    doReset(k);
    sawOvl = 0;
    for (int i = 0; i < NCAP; i++) begin
      if (toA) capA[i] = bitOut;
      else     capB[i] = bitOut;
      sawOvl |= overload;
      @(negedge clk);
    end
  endtask

  function automatic int countDiff(input int upto);
    int d = 0;
    for (int i = 0; i < upto; i++) if (capA[i] !== capB[i]) d++;
    return d;
  endfunction

  task automatic checkPpm(input string req, input longint ones, input int n, input int expPpm);
    longint ppm;
    longint diff;
    ppm  = (ones * 1000000) / n;
    diff = ppm - expPpm;
    if (diff < 0) diff = -diff;
    check(diff <= 1000, req, ppm, expPpm);
  endtask

  initial begin
    longint ones;
    bit     ovl;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bitOut === 1'b1, "R1 bitOut in reset", bitOut, 1);
    check(overload === 1'b0, "R1 overload in reset", overload, 0);

    // R3, R6: table of constant inputs
    for (int v = 0; v < NVEC; v++) begin
      doReset(VEC_K[v]);
      runWindow(NWIN, ones, ovl);
      checkPpm($sformatf("R3 density k=%0d", VEC_K[v]), ones, NWIN, VEC_PPM[v]);
      check(ovl == 1'b0, $sformatf("R6 overload k=%0d", VEC_K[v]), ovl, 0);
    end

    // R7: step without reset from the last table value to -9999
    fracWord = -17'sd9999;
    runWindow(NWIN, ones, ovl);
    checkPpm("R7 density after step", ones, NWIN, 341225);
    check(ovl == 1'b0, "R6 overload after step", ovl, 0);

    // R2, R5: startup bits and input latency
    capture(12288, 1'b1, ovl);
    capture(-12288, 1'b0, ovl);
    check(capA[0] === 1'b1, "R2 first bit", capA[0], 1);
    check(capA[1] === 1'b0, "R2 second bit", capA[1], 0);
    check(capB[0] === 1'b1, "R2 first bit negative k", capB[0], 1);
    check(capB[1] === 1'b0, "R2 second bit negative k", capB[1], 0);
    check(countDiff(4) == 0, "R5 first four bits independent of k", countDiff(4), 0);

    // R4: clamp above and below
    capture(30000, 1'b1, ovl);
    check(ovl == 1'b0, "R6 overload clamped high", ovl, 0);
    capture(12288, 1'b0, ovl);
    check(countDiff(NCAP) == 0, "R4 clamp high stream", countDiff(NCAP), 0);
    capture(32767, 1'b1, ovl);
    check(countDiff(NCAP) == 0, "R4 clamp top of range", countDiff(NCAP), 0);
    capture(-32768, 1'b1, ovl);
    check(ovl == 1'b0, "R6 overload clamped low", ovl, 0);
    capture(-12288, 1'b0, ovl);
    check(countDiff(NCAP) == 0, "R4 clamp low stream", countDiff(NCAP), 0);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(bitOut === 1'b1, "R1 bitOut after mid-run reset", bitOut, 1);
    check(overload === 1'b0, "R1 overload after mid-run reset", overload, 0);
    rst = 1'b0;

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule